// File: doc/BRIEF.md
# Trap State Register Unit

This unit holds the privileged trap state of a 32-bit RISC core. Its registers are a return-address register, a cause register and a status register, plus a flag that records whether the core runs in user or kernel mode. When the pipeline raises a capture strobe, the unit records where execution must resume and a 4-bit trap code. It also places the core in kernel mode. A return strobe sends the core back to user mode and presents the saved address as the restart target.

Software reaches the registers through a combinational read port and a write port, each selected by a register number. Any access made in user mode raises a fault flag. Such a read returns zero and such a write has no effect. The cause register also shows the external request lines, sampled every cycle. Those lines are combined with the mask and enable fields of the status register to form an interrupt request towards the core.

Top module: `trap_state_unit`

## Requirements
- R1: After reset the unit is in kernel mode, and the status, cause and return-address registers all read zero.
- R2: A capture with trap code 8 (system call), 10 (undefined instruction) or 12 (arithmetic overflow) stores the supplied PC minus 4 in the return-address register. The supplied PC is already incremented.
- R3: A capture with trap code 0 (interrupt) stores the supplied PC unchanged.
- R4: A capture writes its trap code into cause bits 5..2 and puts the unit in kernel mode from the next cycle, whatever mode it was in before.
- R5: Cause bits 15..8 show the 8 external request lines as they were at the previous clock edge.
- R6: Status bits 15..8 are mask bits and status bit 0 is the global enable. All other status bits read zero. The interrupt request output is high exactly when the enable is set and some request line's registered copy is high while its mask bit is set.
- R7: Register number 12 selects status, 13 selects cause and 14 selects the return-address register. In kernel mode a read returns the register contents in the same cycle. Any other register number reads zero.
- R8: In user mode any read or write strobe raises the privilege-fault output. Such a read returns zero, and such a write leaves every register unchanged.
- R9: When a capture and a software write to the return-address or cause register happen in the same cycle, the capture's value is kept.
- R10: A return strobe clears kernel mode. If a capture arrives in the same cycle, kernel mode is kept. The restart-address output always shows the return-address register.
- R11: A software write to the cause register changes only bits 5..2. The request bits continue to follow the request lines, and all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Trap capture strobe |
| cap_code | input | 4 | Trap code of the capture |
| cap_pc | input | 32 | Incremented PC at the time of the trap |
| eret | input | 1 | Return-from-trap strobe |
| irq_lines | input | 8 | External interrupt request lines |
| rd_en | input | 1 | Register read strobe |
| rd_num | input | 5 | Register number to read |
| rd_data | output | 32 | Read data, combinational |
| wr_en | input | 1 | Register write strobe |
| wr_num | input | 5 | Register number to write |
| wr_data | input | 32 | Write data |
| kernel_mode | output | 1 | High while in kernel mode |
| priv_fault | output | 1 | User-mode access attempt |
| irq_req | output | 1 | Masked and enabled interrupt request |
| restart_pc | output | 32 | Saved return address |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, 8 request lines and a 4-byte instruction. With these values the bench can compute every expected register word by hand. The fixed field positions (codes in bits 5..2, requests in bits 15..8) can then be checked exactly, and so can the 4-byte return-address adjustment. At this width the bench can also drive all four trap codes, single request lines against partial masks, and the same-cycle collisions of capture with write and of capture with return.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    localparam int REGNUM_W   = 5;
    localparam int CODE_W     = 4;
    localparam int CODE_LSB   = 2;
    localparam int IRQ_LSB    = 8;
    localparam int IE_BIT     = 0;
    localparam logic [REGNUM_W-1:0] REG_STATUS = 5'd12;
    localparam logic [REGNUM_W-1:0] REG_CAUSE  = 5'd13;
    localparam logic [REGNUM_W-1:0] REG_EPC    = 5'd14;

    typedef enum logic [CODE_W-1:0] {
        TRAP_IRQ   = 4'd0,
        TRAP_SYS   = 4'd8,
        TRAP_ILLEG = 4'd10,
        TRAP_OVF   = 4'd12
    } trap_code_e;
endpackage

// File: rtl/tsu_epc_sel.sv
module tsu_epc_sel #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [tsu_pkg::CODE_W-1:0] code,
    input  logic [XLEN-1:0]            pc_inc,
    output logic [XLEN-1:0]            epc_val
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    // Interrupts resume at the next instruction; all other traps point
    // back at the instruction that raised them.
    always_comb begin
        if (code == tsu_pkg::TRAP_IRQ) epc_val = pc_inc;
        else                           epc_val = pc_inc - STEP;
    end
endmodule

// File: rtl/tsu_irq_gate.sv
module tsu_irq_gate #(
    parameter int NIRQ = 8
) (
    input  logic [NIRQ-1:0] pend,
    input  logic [NIRQ-1:0] mask,
    input  logic            ie,
    output logic            req
);
    logic [NIRQ-1:0] hit;

    for (genvar i = 0; i < NIRQ; i++) begin : g_line
        assign hit[i] = pend[i] & mask[i];
    end

    assign req = ie & (|hit);
endmodule

// File: rtl/tsu_access.sv
module tsu_access #(
    parameter int XLEN = 32
) (
    input  logic                         kmode,
    input  logic                         rd_en,
    input  logic [tsu_pkg::REGNUM_W-1:0] rd_num,
    input  logic                         wr_en,
    input  logic [tsu_pkg::REGNUM_W-1:0] wr_num,
    input  logic [XLEN-1:0]              status_w,
    input  logic [XLEN-1:0]              cause_w,
    input  logic [XLEN-1:0]              epc_w,
    output logic [XLEN-1:0]              rd_data,
    output logic                         fault,
    output logic                         we_status,
    output logic                         we_cause,
    output logic                         we_epc
);
    import tsu_pkg::*;

    logic wr_ok;
    assign wr_ok = wr_en & kmode;

    always_comb begin
        rd_data = '0;
        if (rd_en && kmode) begin
            unique case (rd_num)
                REG_STATUS: rd_data = status_w;
                REG_CAUSE:  rd_data = cause_w;
                REG_EPC:    rd_data = epc_w;
                default:    rd_data = '0;
            endcase
        end
    end

    assign we_status = wr_ok & (wr_num == REG_STATUS);
    assign we_cause  = wr_ok & (wr_num == REG_CAUSE);
    assign we_epc    = wr_ok & (wr_num == REG_EPC);
    assign fault     = (rd_en | wr_en) & ~kmode;
endmodule

// File: rtl/trap_state_unit.sv
module trap_state_unit #(
    parameter int XLEN       = 32,
    parameter int NIRQ       = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap_valid,
    input  logic [tsu_pkg::CODE_W-1:0]   cap_code,
    input  logic [XLEN-1:0]              cap_pc,
    input  logic                         eret,
    input  logic [NIRQ-1:0]              irq_lines,
    input  logic                         rd_en,
    input  logic [tsu_pkg::REGNUM_W-1:0] rd_num,
    output logic [XLEN-1:0]              rd_data,
    input  logic                         wr_en,
    input  logic [tsu_pkg::REGNUM_W-1:0] wr_num,
    input  logic [XLEN-1:0]              wr_data,
    output logic                         kernel_mode,
    output logic                         priv_fault,
    output logic                         irq_req,
    output logic [XLEN-1:0]              restart_pc
);
    import tsu_pkg::*;

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    typedef struct packed {
        logic [XLEN-1:0]   epc;
        logic [CODE_W-1:0] code;
        logic [NIRQ-1:0]   pend;
        logic [NIRQ-1:0]   mask;
        logic              ie;
        logic              kmode;
    } state_t;

    state_t st_d, st_q;

    logic [XLEN-1:0] epc_val;
    logic [XLEN-1:0] status_w, cause_w;
    logic            we_status, we_cause, we_epc;

    tsu_epc_sel #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
        .code    (cap_code),
        .pc_inc  (cap_pc),
        .epc_val (epc_val)
    );

    tsu_irq_gate #(.NIRQ(NIRQ)) u_irq (
        .pend (st_q.pend),
        .mask (st_q.mask),
        .ie   (st_q.ie),
        .req  (irq_req)
    );

    always_comb begin
        status_w                   = '0;
        status_w[IRQ_LSB +: NIRQ]  = st_q.mask;
        status_w[IE_BIT]           = st_q.ie;
        cause_w                    = '0;
        cause_w[IRQ_LSB +: NIRQ]   = st_q.pend;
        cause_w[CODE_LSB +: CODE_W] = st_q.code;
    end

    tsu_access #(.XLEN(XLEN)) u_acc (
        .kmode     (st_q.kmode),
        .rd_en     (rd_en),
        .rd_num    (rd_num),
        .wr_en     (wr_en),
        .wr_num    (wr_num),
        .status_w  (status_w),
        .cause_w   (cause_w),
        .epc_w     (st_q.epc),
        .rd_data   (rd_data),
        .fault     (priv_fault),
        .we_status (we_status),
        .we_cause  (we_cause),
        .we_epc    (we_epc)
    );

    // Next state: software writes first, capture last so it wins.
    always_comb begin
        st_d      = st_q;
        st_d.pend = irq_lines;
        if (we_status) begin
            st_d.mask = wr_data[IRQ_LSB +: NIRQ];
            st_d.ie   = wr_data[IE_BIT];
        end
        if (we_cause) st_d.code = wr_data[CODE_LSB +: CODE_W];
        if (we_epc)   st_d.epc  = wr_data;
        if (eret)     st_d.kmode = 1'b0;
        if (cap_valid) begin
            st_d.epc   = epc_val;
            st_d.code  = cap_code;
            st_d.kmode = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.kmode <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign kernel_mode = st_q.kmode;
    assign restart_pc  = st_q.epc;

    // R4
    capture_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> kernel_mode);
    // R2
    epc_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_code != TRAP_IRQ) |=> restart_pc == $past(cap_pc) - STEP);
    // R3
    epc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_code == TRAP_IRQ) |=> restart_pc == $past(cap_pc));
    // R10
    eret_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !cap_valid) |=> !kernel_mode);
    // R8
    user_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !kernel_mode && !cap_valid) |=> $stable(restart_pc));
    // R8
    user_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && priv_fault) |-> rd_data == '0);
    // R9
    cap_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && wr_en) |=> cause_w[CODE_LSB +: CODE_W] == $past(cap_code));
    // R5
    pending_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cause_w[IRQ_LSB +: NIRQ] == $past(irq_lines));
endmodule

// File: tb/sim_trap_state_unit.sv
`timescale 1ns/1ps
module sim_trap_state_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [3:0]  cap_code = '0;
    logic [31:0] cap_pc = '0;
    logic        eret = 1'b0;
    logic [7:0]  irq_lines = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_num = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_num = '0;
    logic [31:0] wr_data = '0;
    logic        kernel_mode, priv_fault, irq_req;
    logic [31:0] restart_pc;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    trap_state_unit u0 (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_code(cap_code),
        .cap_pc(cap_pc), .eret(eret), .irq_lines(irq_lines), .rd_en(rd_en),
        .rd_num(rd_num), .rd_data(rd_data), .wr_en(wr_en), .wr_num(wr_num),
        .wr_data(wr_data), .kernel_mode(kernel_mode), .priv_fault(priv_fault),
        .irq_req(irq_req), .restart_pc(restart_pc)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a read is on the port.
    always @(negedge clk) begin
        if (rd_en && exp_q.size() > 0) begin
            chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic rd(input logic [4:0] n, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        rd_en = 1'b1; rd_num = n;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [4:0] n, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_num = n; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic cap(input logic [3:0] c, input logic [31:0] pc);
        @(posedge clk); #1;
        cap_valid = 1'b1; cap_code = c; cap_pc = pc;
        @(posedge clk); #1;
        cap_valid = 1'b0;
    endtask

    task automatic ret();
        @(posedge clk); #1;
        eret = 1'b1;
        @(posedge clk); #1;
        eret = 1'b0;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        at_neg(); chk(kernel_mode, 1, "R1 kernel after reset");
        rd(12, 32'h0, "R1 status reset");
        rd(13, 32'h0, "R1 cause reset");
        rd(14, 32'h0, "R1 epc reset");

        wr(12, 32'hFFFF_FFFF);
        rd(12, 32'h0000_FF01, "R6 status fields");
        @(posedge clk); #1 irq_lines = 8'h04;
        @(posedge clk); at_neg(); chk(irq_req, 1, "R6 request raised");
        rd(13, 32'h0000_0400, "R5 pending in cause");
        wr(12, 32'h0000_0B01); at_neg(); chk(irq_req, 0, "R6 masked line");
        wr(12, 32'h0000_0400); at_neg(); chk(irq_req, 0, "R6 global enable off");
        wr(12, 32'h0000_0401); at_neg(); chk(irq_req, 1, "R6 enable on");
        @(posedge clk); #1 irq_lines = 8'h00;
        @(posedge clk); at_neg(); chk(irq_req, 0, "R5 line dropped");

        wr(13, 32'hFFFF_FFFF);
        rd(13, 32'h0000_003C, "R11 cause write code only");
        wr(14, 32'h1234_5678);
        rd(14, 32'h1234_5678, "R7 epc readback");
        rd(5, 32'h0, "R7 unmapped number");

        cap(4'd12, 32'h0000_0050);
        rd(14, 32'h0000_004C, "R2 overflow epc");
        rd(13, 32'h0000_0030, "R4 overflow code");

        ret(); at_neg();
        chk(kernel_mode, 0, "R10 return to user");
        chk(restart_pc, 32'h0000_004C, "R10 restart address");
        rd(14, 32'h0, "R8 user read zero");
        @(posedge clk); #1 wr_en = 1'b1; wr_num = 14; wr_data = 32'h0000_DEAD;
        at_neg(); chk(priv_fault, 1, "R8 fault flag");
        @(posedge clk); #1 wr_en = 1'b0;
        at_neg(); chk(restart_pc, 32'h0000_004C, "R8 user write ignored");

        cap(4'd8, 32'h0000_0104);
        at_neg(); chk(kernel_mode, 1, "R4 capture enters kernel");
        rd(14, 32'h0000_0100, "R2 syscall epc");
        rd(13, 32'h0000_0020, "R4 syscall code");

        cap(4'd0, 32'h0000_0200);
        rd(14, 32'h0000_0200, "R3 interrupt epc");
        rd(13, 32'h0000_0000, "R3 interrupt code");

        @(posedge clk); #1;
        cap_valid = 1'b1; cap_code = 4'd10; cap_pc = 32'h0000_0300;
        wr_en = 1'b1; wr_num = 14; wr_data = 32'h0000_AAAA;
        @(posedge clk); #1 cap_valid = 1'b0; wr_en = 1'b0;
        rd(14, 32'h0000_02FC, "R9 capture beats epc write");
        @(posedge clk); #1;
        cap_valid = 1'b1; cap_code = 4'd12; cap_pc = 32'h0000_0400;
        wr_en = 1'b1; wr_num = 13; wr_data = 32'hFFFF_FFFF;
        @(posedge clk); #1 cap_valid = 1'b0; wr_en = 1'b0;
        rd(13, 32'h0000_0030, "R9 capture beats cause write");

        @(posedge clk); #1;
        cap_valid = 1'b1; cap_code = 4'd8; cap_pc = 32'h0000_0504; eret = 1'b1;
        @(posedge clk); #1 cap_valid = 1'b0; eret = 1'b0;
        at_neg(); chk(kernel_mode, 1, "R10 capture beats return");
        rd(14, 32'h0000_0500, "R2 epc with return");

        ret(); at_neg(); chk(kernel_mode, 0, "R10 user again");
        cap(4'd0, 32'h0000_0600);
        at_neg(); chk(kernel_mode, 1, "R4 capture from user");
        chk(restart_pc, 32'h0000_0600, "R3 epc from user");

        repeat (2) @(posedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule